// File: doc/BRIEF.md
# Dual-Port Video Memory with Serial Port

This block models a dual-ported video memory. The storage array is arranged as rows, and each row is a fixed number of bits. A host port gives random word reads and writes. A second port can only be read, and it streams one row out one bit at a time. The host addresses a word by concatenating a row index with a word index inside that row. Reads are registered, so data returns in the cycle after the request.

A single-cycle transfer strobe names a row. In that one cycle, the whole row is copied into an internal shift buffer. From the next cycle on, the serial output shows the current bit. Each single-cycle shift strobe advances the output to the next higher bit position of the row. The shift strobe is synchronous to the main clock.

The array is touched only when the buffer is reloaded. The host port therefore stays free to read and write any row while a row streams out. A bit counter tracks how much of the row is still unsent. From that count come a low-water flag and an empty flag.

Top module: `vid_dualport_mem`

## Requirements
- R1: After reset, `ser_empty` and `ser_low` are 1, and `ser_out` and `host_rdata` are 0.
- R2: A host write with `host_en`=1 and `host_we`=1 stores `host_wdata` at the word selected by `host_addr`, where `host_addr` = {row index, word index}. A host read with `host_en`=1 and `host_we`=0 shows that word on `host_rdata` after the next rising clock edge. `host_rdata` holds its value while no read is made.
- R3: A pulse on `xfer` copies the whole row `xfer_row` into the shift buffer in that clock edge. After the edge, `ser_out` shows row bit 0 and `ser_empty` is 0.
- R4: Each `shift` pulse advances `ser_out` by one position in ascending address order. Row bit k is bit (k mod WORD_W) of word (k div WORD_W).
- R5: While `shift` and `xfer` are both low, `ser_out` and the flags do not change.
- R6: Host reads and writes, including writes to the row being streamed, do not disturb the bit sequence on `ser_out`.
- R7: If `xfer` and a host write hit the same row in one cycle, the buffer gets the row as it was before the write, and the array keeps the written word.
- R8: Let remaining be ROW_BITS minus the number of shifts since the last transfer. `ser_low` is 1 exactly when remaining is less than LOW_MARK.
- R9: After ROW_BITS shifts, `ser_empty` is 1 and `ser_out` is 0. Further shifts keep `ser_out` at 0 and `ser_empty` at 1.
- R10: A transfer made part-way through a stream reloads the buffer and restarts the stream from bit 0 of the new row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+WIDX_W | {row index, word index} |
| host_wdata | input | WORD_W | Write data |
| host_rdata | output | WORD_W | Registered read data |
| xfer | input | 1 | Load a row into the shift buffer |
| xfer_row | input | ROW_W | Row to load |
| shift | input | 1 | Advance the serial output by one bit |
| ser_out | output | 1 | Current serial bit |
| ser_low | output | 1 | Fewer than LOW_MARK bits remain |
| ser_empty | output | 1 | No bits remain |

## Verification
Internal faults show up at the ports within a cycle or two:
- A buffer loaded from the wrong row, or loaded a cycle late, shows a wrong `ser_out` value in the first cycle after `xfer`.
- A wrong shift direction or a lost bit shows a mismatch within a few `shift` pulses.
- A counter that drifts from the buffer shows `ser_low` or `ser_empty` changing one shift early or late at the threshold.
- A leak between the two ports shows up when bits of a row overwritten during streaming reach `ser_out`, or when the overwritten word does not read back from the array.

// File: rtl/vid_dualport_mem.sv
module vid_dualport_mem #(
  parameter int ROW_BITS = 1024,
  parameter int ROWS     = 64,
  parameter int WORD_W   = 16,
  parameter int LOW_MARK = 32,
  localparam int WPR     = ROW_BITS / WORD_W,
  localparam int WIDX_W  = $clog2(WPR),
  localparam int ROW_W   = $clog2(ROWS),
  localparam int ADDR_W  = ROW_W + WIDX_W,
  localparam int CNT_W   = $clog2(ROW_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              xfer,
  input  logic [ROW_W-1:0]  xfer_row,
  input  logic              shift,
  output logic              ser_out,
  output logic              ser_low,
  output logic              ser_empty
);

  logic [ROW_BITS-1:0] mem [ROWS];
  logic [ROW_BITS-1:0] sbuf;
  logic [CNT_W-1:0]    left;

  logic [ROW_W-1:0]  h_row;
  logic [WIDX_W-1:0] h_word;
  int                h_lsb;

  assign h_row  = host_addr[ADDR_W-1:WIDX_W];
  assign h_word = host_addr[WIDX_W-1:0];
  assign h_lsb  = int'(h_word) * WORD_W;

  always_ff @(posedge clk) begin
    if (host_en && host_we)
      mem[h_row][h_lsb +: WORD_W] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      host_rdata <= '0;
    else if (host_en && !host_we)
      host_rdata <= mem[h_row][h_lsb +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbuf <= '0;
      left <= '0;
    end else if (xfer) begin
      sbuf <= mem[xfer_row];
      left <= CNT_W'(ROW_BITS);
    end else if (shift && left != '0) begin
      sbuf <= {1'b0, sbuf[ROW_BITS-1:1]};
      left <= left - CNT_W'(1);
    end
  end

  assign ser_out   = sbuf[0] & ~ser_empty;
  assign ser_empty = (left == '0);
  assign ser_low   = (left < CNT_W'(LOW_MARK));

  a_r3_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !ser_empty);

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !shift) |=> ($stable(ser_out) && $stable(left)));

  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !xfer && !ser_empty) |=> (left == $past(left) - CNT_W'(1)));

  a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ser_empty |-> !ser_out);

  a_r9_empty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_empty && !xfer) |=> ser_empty);

  a_r8_low_before_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ser_empty |-> ser_low);

endmodule

// File: tb/test_vid_dualport_mem.sv
module test_vid_dualport_mem;
  localparam int CLK_P  = 10;
  localparam int NB     = 1024;
  localparam int NR     = 64;
  localparam int W      = 16;
  localparam int WPR    = NB / W;
  localparam int LOWM   = 32;

  logic clk = 0, rst_n = 0;
  logic host_en = 0, host_we = 0;
  logic [11:0] host_addr = '0;
  logic [W-1:0] host_wdata = '0, host_rdata;
  logic xfer = 0, shift = 0;
  logic [5:0] xfer_row = '0;
  logic ser_out, ser_low, ser_empty;

  int checks = 0, errors = 0;
  logic [NB-1:0] ref_mem [NR];

  always #(CLK_P/2) clk = ~clk;

  vid_dualport_mem i_vid_dualport_mem (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .xfer(xfer), .xfer_row(xfer_row), .shift(shift),
    .ser_out(ser_out), .ser_low(ser_low), .ser_empty(ser_empty));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] pat(input int row, input int word, input int seed);
    return W'((row * 16'h0123) ^ (word * 16'h0F0F) ^ seed);
  endfunction

  task automatic wr(input int row, input int word, input logic [W-1:0] d);
    host_en = 1; host_we = 1; host_addr = {6'(row), 6'(word)}; host_wdata = d;
    cyc();
    host_en = 0; host_we = 0;
    ref_mem[row][word*W +: W] = d;
  endtask

  task automatic rd_chk(input string req, input int row, input int word);
    host_en = 1; host_we = 0; host_addr = {6'(row), 6'(word)};
    cyc();
    host_en = 0;
    chk(req, 32'(host_rdata), 32'(ref_mem[row][word*W +: W]));
  endtask

  task automatic fill(input int row, input int seed);
    for (int w = 0; w < WPR; w++) wr(row, w, pat(row, w, seed));
  endtask

  task automatic load(input int row);
    xfer = 1; xfer_row = 6'(row);
    cyc();
    xfer = 0;
  endtask

  task automatic stream(input string req, input logic [NB-1:0] exp,
                        input int from, input int cnt);
    for (int k = from; k < from + cnt; k++) begin
      chk(req, 32'(ser_out), 32'(exp[k]));
      chk("R8", 32'(ser_low), 32'((NB - k) < LOWM));
      shift = 1;
      cyc();
    end
    shift = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty", 32'(ser_empty), 1);
    chk("R1 low", 32'(ser_low), 1);
    chk("R1 ser_out", 32'(ser_out), 0);
    chk("R1 rdata", 32'(host_rdata), 0);
  endtask

  task automatic t_host();
    wr(0, 0, 16'hA5C3); wr(63, 63, 16'hFFFF); wr(12, 7, 16'h0001);
    rd_chk("R2", 0, 0); rd_chk("R2", 63, 63); rd_chk("R2", 12, 7);
    cyc();
    chk("R2 hold", 32'(host_rdata), 32'h0001);
    wr(12, 7, 16'h8000);
    rd_chk("R2 overwrite", 12, 7);
  endtask

  task automatic t_full_stream();
    fill(5, 16'h3C5A);
    load(5);
    chk("R3 not empty", 32'(ser_empty), 0);
    chk("R3 bit0", 32'(ser_out), 32'(ref_mem[5][0]));
    stream("R4", ref_mem[5], 0, NB);
    chk("R9 empty", 32'(ser_empty), 1);
    chk("R9 out", 32'(ser_out), 0);
    shift = 1; repeat (3) cyc(); shift = 0;
    chk("R9 extra shifts out", 32'(ser_out), 0);
    chk("R9 extra shifts empty", 32'(ser_empty), 1);
    chk("R9 low", 32'(ser_low), 1);
  endtask

  task automatic t_hold();
    fill(6, 16'h1248);
    load(6);
    repeat (4) cyc();
    chk("R5 idle bit0", 32'(ser_out), 32'(ref_mem[6][0]));
    stream("R4", ref_mem[6], 0, 5);
    repeat (3) cyc();
    chk("R5 idle bit5", 32'(ser_out), 32'(ref_mem[6][5]));
    chk("R5 idle flags", 32'({ser_low, ser_empty}), 0);
  endtask

  task automatic t_concurrent();
    logic [NB-1:0] snap;
    fill(7, 16'h7E81);
    fill(8, 16'h0550);
    load(7);
    snap = ref_mem[7];
    for (int k = 0; k < 128; k++) begin
      chk("R6", 32'(ser_out), 32'(snap[k]));
      shift = 1;
      host_en = 1;
      if (k % 2 == 0) begin
        host_we = 1; host_addr = {6'd7, 6'(k / 2)}; host_wdata = ~pat(7, k / 2, 16'h7E81);
        ref_mem[7][(k/2)*W +: W] = ~pat(7, k / 2, 16'h7E81);
      end else begin
        host_we = 0; host_addr = {6'd8, 6'(k / 2)};
      end
      cyc();
      if (k % 2 == 1) chk("R6 read", 32'(host_rdata), 32'(ref_mem[8][(k/2)*W +: W]));
    end
    shift = 0; host_en = 0; host_we = 0;
    rd_chk("R6 array", 7, 3);
  endtask

  task automatic t_collide();
    logic [NB-1:0] old;
    fill(9, 16'h6996);
    old = ref_mem[9];
    xfer = 1; xfer_row = 6'd9;
    host_en = 1; host_we = 1; host_addr = {6'd9, 6'd0}; host_wdata = 16'hDEAD;
    cyc();
    xfer = 0; host_en = 0; host_we = 0;
    ref_mem[9][0 +: W] = 16'hDEAD;
    stream("R7 buffer old", old, 0, 24);
    rd_chk("R7 array new", 9, 0);
  endtask

  task automatic t_reload();
    fill(10, 16'h0F1E);
    fill(11, 16'hB00B);
    load(10);
    stream("R10 first", ref_mem[10], 0, 40);
    load(11);
    chk("R10 restart bit0", 32'(ser_out), 32'(ref_mem[11][0]));
    chk("R10 low cleared", 32'(ser_low), 0);
    stream("R10 second", ref_mem[11], 0, 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_host();
    t_full_stream();
    t_hold();
    t_concurrent();
    t_collide();
    t_reload();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule